// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block decides when four output rails and the two upstream converters that feed them are switched on and off. A host steers it with one wake level and four request pins. While the wake level is high, each rising edge on a request pin turns its rail on and each falling edge turns it off, so the rails come up and go down in whatever order the host toggles the pins. The converters start with the first rail and stop once the last rail is off. A 1 ms tick input paces every timed step: the rail readiness windows, the converter start-up watchdog and the stepped power-down and power-up walks.

Faults fall into two classes. A global fault (input undervoltage lockout, converter undervoltage or over-temperature), a converter that does not come up in time, or the wake level dropping all cause every rail to be shut off, one per tick, in the reverse of a parameter order. A single-rail undervoltage removes only that rail and the rails listed as depending on it. The converters stay up in that case. Because the request pins are edge sensitive, a rail removed by any fault returns only after a fresh low-then-high toggle of its pin. The power-good output is driven low unless all four rails are enabled, past their readiness window and reported good, with no fault present.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset the mode output is SLEEP (code 0), all rail and converter enables are low and `pgood_pull_low` is 1; while `wakeup` is low, request edges enable nothing.
- R2: With `wakeup` high and no rail requested the mode is STANDBY (code 1); `wakeup` falling in STANDBY returns the mode to SLEEP one clock later.
- R3: In STANDBY or ACTIVE, a rising edge on `rail_req[i]` sets `rail_en[i]` one clock later, with both converter enables high and mode ACTIVE (code 2); a falling edge clears only `rail_en[i]`.
- R4: `rail_rdy[i]` rises only after FIRST_TICKS ticks (6) when the rail was enabled while no rail was on, and otherwise after NEXT_TICKS ticks (2), counted from its enable, and only while `rail_pg[i]` is high.
- R5: `pgood_pull_low` is 0 only when all four `rail_rdy` bits are 1 and no global fault and no rail undervoltage is present; otherwise it is 1.
- R6: If both `conv_pg` bits are not high by the CONV_TMO_TICKS-th tick (10) after the converters are enabled, the controller runs the full power-down walk and ends in STANDBY.
- R7: When `wakeup` falls with rails on, the rails are cleared one per tick in the reverse of PUP_ORDER (default power-down order 3, 1, 0, 2); on the tick that clears the last slot the converters turn off and the mode becomes SLEEP.
- R8: A global fault (`fault_uvlo`, `fault_conv_uv`, `fault_therm`) runs the same power-down walk and ends in STANDBY while `wakeup` stays high.
- R9: `rail_uv[i]` on an enabled rail clears that rail and every rail in its dependency mask (default: rail 3 depends on rail 2) one clock later, while the mode stays ACTIVE and the converters stay enabled.
- R10: A rail removed by a fault stays off while its request pin remains high, and returns only after that pin goes low and then high again.
- R11: When `wakeup` rises while some request pins are already high, those rails are enabled one slot per tick in PUP_ORDER (default 2, 0, 1, 3), skipping slots whose pin is low.
- R12: When the host has turned every rail off through its pins, the converters switch off and the mode becomes STANDBY one clock after the last rail clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| wakeup | input | 1 | Host wake level |
| rail_req | input | 4 | Edge-sensitive rail request pins |
| rail_pg | input | 4 | Per-rail in-regulation status |
| conv_pg | input | 2 | Per-converter good status |
| fault_uvlo | input | 1 | Input undervoltage lockout |
| fault_conv_uv | input | 1 | Converter undervoltage |
| fault_therm | input | 1 | Over-temperature shutdown |
| rail_uv | input | 4 | Per-rail undervoltage |
| rail_en | output | 4 | Rail enables |
| rail_rdy | output | 4 | Rail ready: enabled, window elapsed, good |
| conv_en | output | 2 | Converter enables |
| mode | output | 2 | 0 SLEEP, 1 STANDBY, 2 ACTIVE |
| pgood_pull_low | output | 1 | 1 drives the power-good line low, 0 releases it |

## Verification
The bench builds the block with its default parameters: four rails, two converters, windows of 6 and 2 ticks, a 10-tick converter watchdog, power-up order 2, 0, 1, 3 and a dependency mask in which rail 3 hangs on rail 2. The bench drives the tick itself, so every millisecond window costs only two clocks. This puts the watchdog expiry, the full four-step power-down walk, the slot skipping of the power-up walk and a dependent-rail cascade within a short run. The asymmetric order makes any slip between the power-up and power-down walks visible in the enable pattern.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_ACTIVE  = 2'd2
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_STBY,
    ST_PUP,
    ST_ACT,
    ST_PDN
  } seq_state_e;

  function automatic pwr_mode_e mode_of(input seq_state_e s);
    case (s)
      ST_SLEEP: mode_of = MODE_SLEEP;
      ST_STBY:  mode_of = MODE_STANDBY;
      default:  mode_of = MODE_ACTIVE;
    endcase
  endfunction

endpackage

// File: rtl/rail_seq_slot.sv
module rail_seq_slot #(
  parameter int FIRST_TICKS = 6,
  parameter int NEXT_TICKS  = 2,
  localparam int MAX_TICKS  = (FIRST_TICKS > NEXT_TICKS) ? FIRST_TICKS : NEXT_TICKS,
  localparam int CNT_W      = $clog2(MAX_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic set_en,
  input  logic clr_en,
  input  logic first,
  input  logic pg,
  output logic en,
  output logic rdy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      cnt <= '0;
      rdy <= 1'b0;
    end else if (clr_en) begin
      en  <= 1'b0;
      cnt <= '0;
      rdy <= 1'b0;
    end else if (set_en) begin
      en  <= 1'b1;
      cnt <= first ? CNT_W'(FIRST_TICKS) : CNT_W'(NEXT_TICKS);
      rdy <= 1'b0;
    end else begin
      if (tick && cnt != '0) cnt <= cnt - 1'b1;
      rdy <= en && (cnt == '0) && pg;
    end
  end

  AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) rdy |-> en); // R4
  AST_FRESH_NOT_RDY: assert property (@(posedge clk) disable iff (rst) (set_en && !clr_en) |=> !rdy); // R4

endmodule

// File: rtl/rail_seq_wdog.sv
module rail_seq_wdog #(
  parameter int N_CONV    = 2,
  parameter int TMO_TICKS = 10,
  localparam int CNT_W    = $clog2(TMO_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              conv_on,
  input  logic [N_CONV-1:0] conv_pg,
  output logic              timeout
);

  logic [CNT_W-1:0] cnt;
  logic             ok;

  always_ff @(posedge clk) begin
    if (rst || !conv_on) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (&conv_pg) begin
      ok <= 1'b1;
    end else if (tick && !ok && cnt != CNT_W'(TMO_TICKS)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign timeout = conv_on && !ok && !(&conv_pg) && tick && (cnt == CNT_W'(TMO_TICKS - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(TMO_TICKS)); // R6

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int N_RAILS        = 4,
  parameter int N_CONV         = 2,
  parameter int FIRST_TICKS    = 6,
  parameter int NEXT_TICKS     = 2,
  parameter int CONV_TMO_TICKS = 10,
  localparam int IDX_W         = (N_RAILS > 1) ? $clog2(N_RAILS) : 1,
  parameter logic [N_RAILS*IDX_W-1:0]   PUP_ORDER = 8'b11_01_00_10,
  parameter logic [N_RAILS*N_RAILS-1:0] DEP_MASK  = 16'h0800
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1ms,
  input  logic               wakeup,
  input  logic [N_RAILS-1:0] rail_req,
  input  logic [N_RAILS-1:0] rail_pg,
  input  logic [N_CONV-1:0]  conv_pg,
  input  logic               fault_uvlo,
  input  logic               fault_conv_uv,
  input  logic               fault_therm,
  input  logic [N_RAILS-1:0] rail_uv,
  output logic [N_RAILS-1:0] rail_en,
  output logic [N_RAILS-1:0] rail_rdy,
  output logic [N_CONV-1:0]  conv_en,
  output logic [1:0]         mode,
  output logic               pgood_pull_low
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_RAILS - 1);

  seq_state_e         state, state_n;
  pwr_mode_e          mode_q;
  logic [IDX_W-1:0]   seq_idx, idx_n;
  logic [N_CONV-1:0]  conv_n;
  logic [N_RAILS-1:0] req_q, rise, fall;
  logic [N_RAILS-1:0] set_vec, clr_vec, uv_kill;
  logic               first_rail, glb_fault, tmo, abort;

  function automatic logic [IDX_W-1:0] ord_at(input logic [IDX_W-1:0] k);
    ord_at = PUP_ORDER[k*IDX_W +: IDX_W];
  endfunction

  assign rise       = rail_req & ~req_q;
  assign fall       = ~rail_req & req_q;
  assign glb_fault  = fault_uvlo | fault_conv_uv | fault_therm;
  assign first_rail = ~(|rail_en);
  assign abort      = !wakeup || glb_fault || tmo;

  always_comb begin
    uv_kill = '0;
    for (int i = 0; i < N_RAILS; i++) begin
      if (rail_uv[i] && rail_en[i]) begin
        uv_kill    = uv_kill | DEP_MASK[i*N_RAILS +: N_RAILS];
        uv_kill[i] = 1'b1;
      end
    end
  end

  rail_seq_wdog #(
    .N_CONV    (N_CONV),
    .TMO_TICKS (CONV_TMO_TICKS)
  ) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1ms),
    .conv_on (&conv_en),
    .conv_pg (conv_pg),
    .timeout (tmo)
  );

  for (genvar g = 0; g < N_RAILS; g++) begin : gen_slot
    rail_seq_slot #(
      .FIRST_TICKS (FIRST_TICKS),
      .NEXT_TICKS  (NEXT_TICKS)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_1ms),
      .set_en (set_vec[g]),
      .clr_en (clr_vec[g]),
      .first  (first_rail),
      .pg     (rail_pg[g]),
      .en     (rail_en[g]),
      .rdy    (rail_rdy[g])
    );
  end

  always_comb begin
    state_n = state;
    idx_n   = seq_idx;
    conv_n  = conv_en;
    set_vec = '0;
    clr_vec = '0;
    case (state)
      ST_SLEEP: begin
        if (wakeup) begin
          if (|rail_req) begin
            state_n = ST_PUP;
            conv_n  = '1;
            idx_n   = '0;
          end else begin
            state_n = ST_STBY;
          end
        end
      end
      ST_STBY: begin
        if (!wakeup) begin
          state_n = ST_SLEEP;
        end else if (|rise) begin
          set_vec = rise;
          conv_n  = '1;
          state_n = ST_ACT;
        end
      end
      ST_PUP: begin
        if (abort) begin
          state_n = ST_PDN;
          idx_n   = LAST_IDX;
        end else begin
          clr_vec = uv_kill;
          if (tick_1ms) begin
            if (rail_req[ord_at(seq_idx)]) set_vec[ord_at(seq_idx)] = 1'b1;
            if (seq_idx == LAST_IDX) state_n = ST_ACT;
            else                     idx_n   = seq_idx + 1'b1;
          end
        end
      end
      ST_ACT: begin
        if (abort) begin
          state_n = ST_PDN;
          idx_n   = LAST_IDX;
        end else if (rail_en == '0 && rise == '0) begin
          conv_n  = '0;
          state_n = ST_STBY;
        end else begin
          set_vec = rise;
          clr_vec = fall | uv_kill;
        end
      end
      ST_PDN: begin
        if (tick_1ms) begin
          clr_vec[ord_at(seq_idx)] = 1'b1;
          if (seq_idx == '0) begin
            conv_n  = '0;
            state_n = wakeup ? ST_STBY : ST_SLEEP;
          end else begin
            idx_n = seq_idx - 1'b1;
          end
        end
      end
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_SLEEP;
      mode_q         <= MODE_SLEEP;
      seq_idx        <= '0;
      conv_en        <= '0;
      req_q          <= '0;
      pgood_pull_low <= 1'b1;
    end else begin
      state          <= state_n;
      mode_q         <= mode_of(state_n);
      seq_idx        <= idx_n;
      conv_en        <= conv_n;
      req_q          <= rail_req;
      pgood_pull_low <= ~(&rail_rdy) | glb_fault | (|rail_uv);
    end
  end

  assign mode = mode_q;

  AST_RAIL_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst) (|rail_en) |-> (&conv_en)); // R3
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst) (mode_q == MODE_SLEEP) |-> (rail_en == '0 && conv_en == '0)); // R1
  AST_PDN_ONE_STEP: assert property (@(posedge clk) disable iff (rst) (state == ST_PDN) |=> ($countones($past(rail_en) & ~rail_en) <= 1)); // R7
  AST_TMO_SHUTS: assert property (@(posedge clk) disable iff (rst) (tmo && state == ST_ACT) |=> (state == ST_PDN)); // R6
  AST_FAULT_PG: assert property (@(posedge clk) disable iff (rst) glb_fault |=> pgood_pull_low); // R5
  AST_UV_KEEPS_CONV: assert property (@(posedge clk) disable iff (rst) (state == ST_ACT && |(rail_uv & rail_en) && !abort) |=> (&conv_en)); // R9

endmodule

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1ms = 1'b0;
  logic       wakeup = 1'b0;
  logic [3:0] rail_req = '0;
  logic [3:0] rail_pg = 4'hF;
  logic [1:0] conv_pg = 2'b11;
  logic       fault_uvlo = 1'b0;
  logic       fault_conv_uv = 1'b0;
  logic       fault_therm = 1'b0;
  logic [3:0] rail_uv = '0;
  logic [3:0] rail_en, rail_rdy;
  logic [1:0] conv_en, mode;
  logic       pgood_pull_low;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rail_seq_ctrl u_dut (
    .clk            (clk),
    .rst            (rst),
    .tick_1ms       (tick_1ms),
    .wakeup         (wakeup),
    .rail_req       (rail_req),
    .rail_pg        (rail_pg),
    .conv_pg        (conv_pg),
    .fault_uvlo     (fault_uvlo),
    .fault_conv_uv  (fault_conv_uv),
    .fault_therm    (fault_therm),
    .rail_uv        (rail_uv),
    .rail_en        (rail_en),
    .rail_rdy       (rail_rdy),
    .conv_en        (conv_en),
    .mode           (mode),
    .pgood_pull_low (pgood_pull_low)
  );

  task automatic clk_n(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_1ms = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 mode after reset", 32'(mode), 0);
    chk("R1 rails after reset", 32'(rail_en), 0);
    chk("R1 conv after reset", 32'(conv_en), 0);
    chk("R1 pgood after reset", 32'(pgood_pull_low), 1);
    rail_req = 4'b0001;
    clk_n(2);
    chk("R1 request ignored in sleep", 32'(rail_en), 0);
    chk("R1 mode stays sleep", 32'(mode), 0);
    rail_req = '0;
    clk_n(1);
  endtask

  task automatic t_standby;
    wakeup = 1'b1;
    clk_n(1);
    chk("R2 standby on wake", 32'(mode), 1);
    wakeup = 1'b0;
    clk_n(1);
    chk("R2 sleep on wake low", 32'(mode), 0);
    wakeup = 1'b1;
    clk_n(1);
    chk("R2 standby again", 32'(mode), 1);
  endtask

  task automatic t_ordered_up;
    rail_req[1] = 1'b1;
    clk_n(1);
    chk("R3 first rail on", 32'(rail_en), 32'h2);
    chk("R3 conv on", 32'(conv_en), 32'h3);
    chk("R3 mode active", 32'(mode), 2);
    tick_n(5);
    chk("R4 first rail not ready at 5", 32'(rail_rdy[1]), 0);
    tick_n(1);
    chk("R4 first rail ready at 6", 32'(rail_rdy[1]), 1);
    rail_req[3] = 1'b1;
    clk_n(1);
    chk("R3 second rail on", 32'(rail_en), 32'hA);
    tick_n(1);
    chk("R4 later rail not ready at 1", 32'(rail_rdy[3]), 0);
    tick_n(1);
    chk("R4 later rail ready at 2", 32'(rail_rdy[3]), 1);
    chk("R5 pgood low with rails missing", 32'(pgood_pull_low), 1);
    rail_req[0] = 1'b1;
    rail_req[2] = 1'b1;
    clk_n(1);
    tick_n(2);
    chk("R4 all rails ready", 32'(rail_rdy), 32'hF);
    clk_n(1);
    chk("R5 pgood released", 32'(pgood_pull_low), 0);
    rail_pg[0] = 1'b0;
    clk_n(2);
    chk("R5 pgood low on lost regulation", 32'(pgood_pull_low), 1);
    rail_pg[0] = 1'b1;
    clk_n(2);
    rail_req[3] = 1'b0;
    clk_n(1);
    chk("R3 falling edge clears one rail", 32'(rail_en), 32'h7);
    chk("R3 still active", 32'(mode), 2);
  endtask

  task automatic t_rail_uv;
    rail_req[3] = 1'b1;
    clk_n(1);
    tick_n(2);
    chk("R3 all four on", 32'(rail_en), 32'hF);
    rail_uv[2] = 1'b1;
    clk_n(1);
    chk("R9 rail and dependent off", 32'(rail_en), 32'h3);
    chk("R9 mode active", 32'(mode), 2);
    chk("R9 conv kept", 32'(conv_en), 32'h3);
    chk("R9 pgood low", 32'(pgood_pull_low), 1);
    rail_uv = '0;
    clk_n(2);
    chk("R10 no return with pin high", 32'(rail_en), 32'h3);
    rail_req[2] = 1'b0;
    clk_n(1);
    rail_req[2] = 1'b1;
    clk_n(1);
    chk("R10 returns after toggle", 32'(rail_en), 32'h7);
    chk("R10 dependent waits for own toggle", 32'(rail_en[3]), 0);
  endtask

  task automatic t_pwrdown;
    rail_req[3] = 1'b0;
    clk_n(1);
    rail_req[3] = 1'b1;
    clk_n(1);
    chk("R3 four on before wake drop", 32'(rail_en), 32'hF);
    wakeup = 1'b0;
    clk_n(1);
    chk("R7 nothing off before tick", 32'(rail_en), 32'hF);
    tick_n(1);
    chk("R7 step 1 rail 3", 32'(rail_en), 32'h7);
    tick_n(1);
    chk("R7 step 2 rail 1", 32'(rail_en), 32'h5);
    tick_n(1);
    chk("R7 step 3 rail 0", 32'(rail_en), 32'h4);
    chk("R7 conv on mid walk", 32'(conv_en), 32'h3);
    tick_n(1);
    chk("R7 step 4 all off", 32'(rail_en), 0);
    chk("R7 conv off", 32'(conv_en), 0);
    chk("R7 sleep", 32'(mode), 0);
  endtask

  task automatic t_wake_pup;
    rail_req = 4'b0101;
    clk_n(1);
    wakeup = 1'b1;
    clk_n(1);
    chk("R11 walk started", 32'(mode), 2);
    chk("R11 conv on", 32'(conv_en), 32'h3);
    chk("R11 no rail before tick", 32'(rail_en), 0);
    tick_n(1);
    chk("R11 slot 0 rail 2", 32'(rail_en), 32'h4);
    tick_n(1);
    chk("R11 slot 1 rail 0", 32'(rail_en), 32'h5);
    tick_n(2);
    chk("R11 skipped slots", 32'(rail_en), 32'h5);
  endtask

  task automatic t_all_off;
    rail_req[0] = 1'b0;
    clk_n(1);
    chk("R3 rail 0 off", 32'(rail_en), 32'h4);
    rail_req[2] = 1'b0;
    clk_n(1);
    chk("R12 last rail off", 32'(rail_en), 0);
    clk_n(1);
    chk("R12 conv off", 32'(conv_en), 0);
    chk("R12 standby", 32'(mode), 1);
  endtask

  task automatic t_global_fault;
    rail_req = 4'b0011;
    clk_n(1);
    chk("R3 two rails on", 32'(rail_en), 32'h3);
    fault_therm = 1'b1;
    clk_n(1);
    chk("R5 pgood low on fault", 32'(pgood_pull_low), 1);
    tick_n(4);
    chk("R8 rails off", 32'(rail_en), 0);
    chk("R8 conv off", 32'(conv_en), 0);
    chk("R8 standby", 32'(mode), 1);
    fault_therm = 1'b0;
    clk_n(2);
    chk("R10 no restart on level", 32'(rail_en), 0);
    rail_req = '0;
    clk_n(1);
    rail_req = 4'b0001;
    clk_n(1);
    chk("R10 restart after toggle", 32'(rail_en), 32'h1);
    rail_req = '0;
    clk_n(2);
  endtask

  task automatic t_conv_tmo;
    conv_pg = 2'b01;
    rail_req[1] = 1'b1;
    clk_n(1);
    chk("R6 rail on", 32'(rail_en), 32'h2);
    tick_n(9);
    chk("R6 still active at 9", 32'(mode), 2);
    chk("R6 rail kept at 9", 32'(rail_en), 32'h2);
    tick_n(1);
    tick_n(3);
    chk("R6 rails off in walk", 32'(rail_en), 0);
    chk("R6 conv on until last slot", 32'(conv_en), 32'h3);
    tick_n(1);
    chk("R6 conv off", 32'(conv_en), 0);
    chk("R6 standby", 32'(mode), 1);
    conv_pg = 2'b11;
    rail_req = '0;
    clk_n(1);
  endtask

  initial begin
    clk_n(4);
    rst = 1'b0;
    clk_n(1);
    t_reset();
    t_standby();
    t_ordered_up();
    t_rail_uv();
    t_pwrdown();
    t_wake_pup();
    t_all_off();
    t_global_fault();
    t_conv_tmo();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule